// File: doc/BRIEF.md
# Dual-Capture Pulse Width Timer

This block measures pulse widths on one input pin. A 16-bit up-counter runs freely from a prescaled tick. Two capture registers hold snapshots of that counter. Register B takes the count on every valid edge of the measurement pin. Register A can take the count on the opposite edge of the same pin. Software subtracts the two snapshots to get the high time, or the low time, in count ticks.

A second input pin, the auxiliary pin, shares register A. In normal capture mode an auxiliary edge loads register A. In inverse-edge mode the auxiliary pin does not load anything, but it still raises the register-A interrupt, so it can serve as an extra interrupt source. Each capture gives a one-cycle interrupt pulse. A counter wrap sets a sticky overflow flag, which software clears by pulsing a clear input.

Both pins are first synchronized with two flops, then edge-detected in the system clock domain.

Top module: `dual_capture_timer`

## Requirements
- R1: While `cnt_en` is high, the counter advances by one per tick. The tick comes every clock for `clk_sel`=00, every 4th clock for 01 and every 16th clock for 10. Code 11 is prohibited and gives no ticks, so the count holds. A high phase of H clocks, with H a multiple of the divisor, therefore measures H divided by the divisor.
- R2: While `cnt_en` is low, the counter and the prescaler are held at zero, so every capture taken then reads 0.
- R3: When a tick arrives with the count at 0xFFFF, the count wraps to 0 and `ovf_flag` is set. The flag stays set until a cycle with `ovf_clr` high clears it. If a wrap and a clear arrive in the same cycle, the wrap wins. After reset the flag is 0.
- R4: Register B loads the count on each valid edge of `meas_in`. The edge is chosen by `meas_edge_sel`: 00 falling, 01 rising, 11 both. Code 10 is prohibited and means no edge, so register B never loads and `irq_b` never pulses.
- R5: With `inv_cap_mode`=1, register A loads the count on the edge of `meas_in` opposite to the valid edge: rising when 00 is selected, falling when 01 is selected.
- R6: With `meas_edge_sel`=11, register A never loads, in either capture mode.
- R7: With `inv_cap_mode`=1, a valid edge of `aux_in` pulses `irq_a` but leaves register A unchanged. The edge is chosen by `aux_edge_sel`, which uses the same encoding as `meas_edge_sel`.
- R8: With `inv_cap_mode`=0, a valid edge of `aux_in` pulses `irq_a`, and it loads register A unless R6 applies. A load from `aux_in` and a load from `meas_in` in the same cycle take the same count.
- R9: `irq_a` and `irq_b` are registered pulses that are high in the cycle in which their register shows the new value. An isolated edge gives a pulse of exactly one cycle. A register never changes in a cycle without its pulse. Both pulses and both registers are 0 after reset.
- R10: Capture and pulse appear on the third rising clock edge after the input pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter run enable; low clears counter and prescaler |
| clk_sel | input | 2 | Tick divisor select: 00 /1, 01 /4, 10 /16, 11 stopped |
| meas_edge_sel | input | 2 | Valid edge of `meas_in`: 00 fall, 01 rise, 11 both, 10 none |
| aux_edge_sel | input | 2 | Valid edge of `aux_in`, same encoding |
| inv_cap_mode | input | 1 | 1: register A captures the inverse edge of `meas_in` |
| meas_in | input | 1 | Measurement pin (asynchronous) |
| aux_in | input | 1 | Auxiliary pin (asynchronous) |
| ovf_clr | input | 1 | Clears `ovf_flag` when high |
| cap_a | output | 16 | Capture register A |
| cap_b | output | 16 | Capture register B |
| irq_a | output | 1 | One-cycle pulse per register-A event |
| irq_b | output | 1 | One-cycle pulse per register-B capture |
| ovf_flag | output | 1 | Sticky counter-wrap flag |

## Verification
Most faults in this block show up at the ports as wrong width arithmetic. A prescaler that ticks at the wrong rate scales every measured high and low time by the wrong factor, and the mismatch appears on the first pulse measured. A swapped edge decode, or a wrong inverse-edge decode, puts the snapshots in the wrong registers, so the differences come out negative or zero. An extra or missing synchronizer stage moves the interrupt pulse off its third-edge slot, and this is visible within a few cycles of a pin change. A broken wrap or a flag that fails to stay set only shows after a full 65536-tick sweep of the counter.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int SEL_W = 2;
  localparam int PRE_W = 4;

  localparam logic [SEL_W-1:0] EDGE_FALL = 2'b00;
  localparam logic [SEL_W-1:0] EDGE_RISE = 2'b01;
  localparam logic [SEL_W-1:0] EDGE_NONE = 2'b10;
  localparam logic [SEL_W-1:0] EDGE_BOTH = 2'b11;

  // Valid edge decode for a selected edge code
  function automatic logic edge_hit(input logic [SEL_W-1:0] sel,
                                    input logic rise, input logic fall);
    case (sel)
      EDGE_FALL: return fall;
      EDGE_RISE: return rise;
      EDGE_BOTH: return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

  // Opposite-edge decode; no opposite edge exists for both or none
  function automatic logic inv_hit(input logic [SEL_W-1:0] sel,
                                   input logic rise, input logic fall);
    case (sel)
      EDGE_FALL: return rise;
      EDGE_RISE: return fall;
      default:   return 1'b0;
    endcase
  endfunction

  // Prescaler tick: divisor 4**sel for sel 0..2, stopped for sel 3
  function automatic logic pre_tick(input logic [SEL_W-1:0] sel,
                                    input logic [PRE_W-1:0] pre);
    case (sel)
      2'd0:    return 1'b1;
      2'd1:    return &pre[1:0];
      2'd2:    return &pre[3:0];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dct_sync_edge.sv
module dct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
  assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/dct_timebase.sv
module dct_timebase
  import dct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_flag
);
  logic [PRE_W-1:0] pre;
  logic             tick;
  logic             wrap;

  assign tick = en & pre_tick(clk_sel, pre);
  assign wrap = tick & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (!en) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= pre + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (wrap)    ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/dct_capture_unit.sv
module dct_capture_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         event_in,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      irq <= 1'b0;
    end else begin
      if (load) q <= din;
      irq <= event_in;
    end
  end
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
  import dct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [1:0]       clk_sel,
  input  logic [1:0]       meas_edge_sel,
  input  logic [1:0]       aux_edge_sel,
  input  logic             inv_cap_mode,
  input  logic             meas_in,
  input  logic             aux_in,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cap_a,
  output logic [CNT_W-1:0] cap_b,
  output logic             irq_a,
  output logic             irq_b,
  output logic             ovf_flag
);
  localparam int NPINS = 2;
  localparam int P_MEAS = 0;
  localparam int P_AUX  = 1;

  logic [NPINS-1:0] pin_vec, rise_v, fall_v;
  logic [CNT_W-1:0] cnt_val;

  // named events, visible to the checker
  logic meas_valid_ev, meas_inv_ev, aux_valid_ev;
  logic load_a, load_b, event_a;

  assign pin_vec = {aux_in, meas_in};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    dct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_vec[g]),
      .rise (rise_v[g]),
      .fall (fall_v[g])
    );
  end

  dct_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cnt_en),
    .clk_sel (clk_sel),
    .ovf_clr (ovf_clr),
    .cnt     (cnt_val),
    .ovf_flag(ovf_flag)
  );

  assign meas_valid_ev = edge_hit(meas_edge_sel, rise_v[P_MEAS], fall_v[P_MEAS]);
  assign meas_inv_ev   = inv_hit(meas_edge_sel, rise_v[P_MEAS], fall_v[P_MEAS]);
  assign aux_valid_ev  = edge_hit(aux_edge_sel, rise_v[P_AUX], fall_v[P_AUX]);

  assign load_b  = meas_valid_ev;
  assign load_a  = inv_cap_mode ? meas_inv_ev
                                : (aux_valid_ev && (meas_edge_sel != EDGE_BOTH));
  assign event_a = inv_cap_mode ? (meas_inv_ev | aux_valid_ev) : aux_valid_ev;

  dct_capture_unit #(.W(CNT_W)) u_cap_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_a),
    .event_in(event_a),
    .din     (cnt_val),
    .q       (cap_a),
    .irq     (irq_a)
  );

  dct_capture_unit #(.W(CNT_W)) u_cap_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_b),
    .event_in(load_b),
    .din     (cnt_val),
    .q       (cap_b),
    .irq     (irq_b)
  );
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [1:0]       clk_sel,
  input logic [1:0]       meas_edge_sel,
  input logic             inv_cap_mode,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] cap_a,
  input logic [CNT_W-1:0] cap_b,
  input logic             irq_a,
  input logic             irq_b,
  input logic             ovf_flag,
  input logic [CNT_W-1:0] cnt_val,
  input logic             meas_inv_ev
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cnt_val) && $past(cnt_en)) |-> (cnt_val == CNT_W'($past(cnt_val) + 1'b1))); // R1
  AST_CNT_PROHIBITED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_en) && $past(clk_sel) == 2'b11) |-> $stable(cnt_val)); // R1
  AST_CNT_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_en) |-> (cnt_val == '0)); // R2
  AST_OVF_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (cnt_val == '0)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R3
  AST_INV_AUX_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cap_a) && $past(inv_cap_mode)) |-> $past(meas_inv_ev)); // R7
  AST_BOTH_NO_CAP_A: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(meas_edge_sel) == 2'b11) |-> $stable(cap_a)); // R6
  AST_CAP_A_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_a) |-> irq_a); // R9
  AST_CAP_B_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_b) |-> irq_b); // R9
endmodule

bind dual_capture_timer dct_checker #(.CNT_W(CNT_W)) u_dct_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_en       (cnt_en),
  .clk_sel      (clk_sel),
  .meas_edge_sel(meas_edge_sel),
  .inv_cap_mode (inv_cap_mode),
  .ovf_clr      (ovf_clr),
  .cap_a        (cap_a),
  .cap_b        (cap_b),
  .irq_a        (irq_a),
  .irq_b        (irq_b),
  .ovf_flag     (ovf_flag),
  .cnt_val      (cnt_val),
  .meas_inv_ev  (meas_inv_ev)
);

// File: tb/test_dual_capture_timer.sv
module test_dual_capture_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [1:0]  clk_sel = 2'b00;
  logic [1:0]  meas_edge_sel = 2'b01;
  logic [1:0]  aux_edge_sel = 2'b01;
  logic        inv_cap_mode = 1'b1;
  logic        meas_in = 1'b0;
  logic        aux_in = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [15:0] cap_a, cap_b;
  logic        irq_a, irq_b, ovf_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_capture_timer i_dual_capture_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clk_sel(clk_sel),
    .meas_edge_sel(meas_edge_sel), .aux_edge_sel(aux_edge_sel),
    .inv_cap_mode(inv_cap_mode), .meas_in(meas_in), .aux_in(aux_in),
    .ovf_clr(ovf_clr), .cap_a(cap_a), .cap_b(cap_b), .irq_a(irq_a),
    .irq_b(irq_b), .ovf_flag(ovf_flag)
  );

  // {clk_sel, meas_edge_sel, high cycles, low cycles}; inverse-edge mode
  localparam logic [19:0] VEC [7] = '{
    {2'd0, 2'b01, 8'd32, 8'd48},
    {2'd1, 2'b01, 8'd64, 8'd32},
    {2'd2, 2'b01, 8'd96, 8'd160},
    {2'd0, 2'b00, 8'd40, 8'd24},
    {2'd1, 2'b00, 8'd48, 8'd80},
    {2'd0, 2'b11, 8'd20, 8'd36},
    {2'd3, 2'b01, 8'd32, 8'd32}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_en = 1'b0; meas_in = 1'b0; aux_in = 1'b0; ovf_clr = 1'b0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  function automatic longint ticks_for(input logic [1:0] sel, input int cycles);
    if (sel == 2'd3) return 0;
    return cycles / (1 << (2 * sel));
  endfunction

  initial begin
    logic [15:0] s1a, s1b, s2a, s2b, s3a, s3b, a0, a1, b1;
    logic [1:0] csel, msel;
    int hi, lo;

    // reset state
    do_reset();
    chk("R9 reset cap_a", cap_a, 0);
    chk("R9 reset cap_b", cap_b, 0);
    chk("R9 reset irqs", {irq_a, irq_b}, 0);
    chk("R3 reset ovf_flag", ovf_flag, 0);

    // table of width measurements
    for (int i = 0; i < 7; i++) begin
      csel = VEC[i][19:18]; msel = VEC[i][17:16];
      hi = int'(VEC[i][15:8]); lo = int'(VEC[i][7:0]);
      do_reset();
      clk_sel = csel; meas_edge_sel = msel; inv_cap_mode = 1'b1; cnt_en = 1'b1;
      cyc(16);
      meas_in = 1'b1; cyc(hi); s1a = cap_a; s1b = cap_b;
      meas_in = 1'b0; cyc(lo); s2a = cap_a; s2b = cap_b;
      meas_in = 1'b1; cyc(16); s3a = cap_a; s3b = cap_b;
      if (msel == 2'b01) begin
        chk("R1 R5 high width rise-valid", 16'(s2a - s1b), ticks_for(csel, hi));
        chk("R1 R4 low width rise-valid",  16'(s3b - s2a), ticks_for(csel, lo));
      end else if (msel == 2'b00) begin
        chk("R1 R4 high width fall-valid", 16'(s2b - s1a), ticks_for(csel, hi));
        chk("R1 R5 low width fall-valid",  16'(s3a - s2b), ticks_for(csel, lo));
      end else begin
        chk("R4 high width both-edges", 16'(s3b - s3b + s2b - s1b), ticks_for(csel, hi));
        chk("R4 low width both-edges",  16'(s3b - s2b), ticks_for(csel, lo));
        chk("R6 cap_a idle with both edges", s3a, 0);
      end
    end

    // R10 latency and R9 pulse width
    do_reset();
    clk_sel = 2'd0; meas_edge_sel = 2'b01; inv_cap_mode = 1'b1; cnt_en = 1'b1;
    cyc(10);
    meas_in = 1'b1;
    cyc(2); chk("R10 irq_b low before third edge", irq_b, 0);
    cyc(1); chk("R10 irq_b at third edge", irq_b, 1);
    cyc(1); chk("R9 irq_b single cycle", irq_b, 0);

    // R5 then R7: aux edge in inverse mode pulses irq_a, no load
    cyc(5);
    meas_in = 1'b0; cyc(6); a0 = cap_a;
    chk("R5 cap_a loaded on inverse edge", (a0 != 0), 1);
    aux_edge_sel = 2'b01; aux_in = 1'b1;
    cyc(3); chk("R7 irq_a on aux edge", irq_a, 1);
    chk("R7 cap_a unchanged", cap_a, a0);
    cyc(3);

    // R8: normal mode, aux falling edge loads cap_a same count as cap_b
    inv_cap_mode = 1'b0; aux_edge_sel = 2'b00;
    aux_in = 1'b0; meas_in = 1'b1;
    cyc(3);
    chk("R8 irq_a on aux fall", irq_a, 1);
    chk("R8 irq_b same cycle", irq_b, 1);
    chk("R8 cap_a equals cap_b", cap_a, cap_b);
    chk("R8 cap_a changed", (cap_a != a0), 1);
    cyc(3);

    // R6 in normal mode: both-edge select blocks load, irq still raised
    meas_edge_sel = 2'b11; aux_edge_sel = 2'b01; a1 = cap_a;
    aux_in = 1'b1;
    cyc(3);
    chk("R8 irq_a with both-edge select", irq_a, 1);
    chk("R6 cap_a held with both-edge select", cap_a, a1);
    cyc(3);

    // R4: prohibited edge code 10 gives no capture
    meas_edge_sel = 2'b10; b1 = cap_b;
    meas_in = 1'b0; cyc(3); chk("R4 no irq_b on code 10 fall", irq_b, 0);
    cyc(3);
    meas_in = 1'b1; cyc(3); chk("R4 no irq_b on code 10 rise", irq_b, 0);
    chk("R4 cap_b held on code 10", cap_b, b1);
    cyc(3);

    // R2: disabled counter captures zero
    meas_edge_sel = 2'b01; inv_cap_mode = 1'b1; cnt_en = 1'b0;
    cyc(3);
    meas_in = 1'b0; cyc(6);
    chk("R2 cap_a zero while disabled", cap_a, 0);
    meas_in = 1'b1; cyc(6);
    chk("R2 cap_b zero while disabled", cap_b, 0);

    // R3: overflow after a full sweep
    do_reset();
    clk_sel = 2'd0; cnt_en = 1'b1;
    cyc(65535);
    chk("R3 no overflow before wrap", ovf_flag, 0);
    cyc(1);
    chk("R3 overflow at wrap", ovf_flag, 1);
    cyc(10);
    chk("R3 overflow sticky", ovf_flag, 1);
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    chk("R3 overflow cleared", ovf_flag, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule